// File: doc/BRIEF.md
# Line-Splitting DMA Request Sequencer

This block turns one DMA transfer (a start byte address, a byte count and a direction) into a series of memory requests. No request crosses a cache line. The first request begins at the start address and stops at the end of its line or at the end of the transfer, whichever comes first. Each later request begins on a line boundary and covers a whole line or whatever bytes are left. The block keeps only one request in flight. It issues the next request only after the memory side returns a response for the previous one: read data for a load, an acknowledgement for a store.

For stores the block fetches payload through a window port. It shows the index of the next payload byte it needs, and the requester returns one line's worth of payload starting at that index. The block places the bytes of each chunk in their line lanes. For loads it shifts the returned line so that the chunk's first byte lands in lane 0, and presents it with byte enables and the chunk's index within the transfer. A one-cycle completion pulse marks the end of the transfer. The block is idle again in that same cycle, so a requester that was refused earlier can start its next transfer at once.

Top module: `dma_line_splitter`

## Requirements
- R1: When idle, a request with nonzero length gets `xfer_accept` high in the same cycle, and `busy` is high from the next cycle on.
- R2: A request arriving while busy gets `xfer_full` high and `xfer_accept` low, and leaves the active transfer's chunks unchanged.
- R3: A request with zero length while idle gets `xfer_bad` high, starts nothing, and `busy` and `req_valid` stay low.
- R4: The first chunk appears on `req_valid` in the cycle after acceptance. Its `req_offset` is the low log2(LINE_BYTES) address bits and its `req_len` is min(length, LINE_BYTES - offset).
- R5: Every later chunk has `req_offset` 0, `req_line_addr` equal to start + bytes completed, and `req_len` equal to min(remaining bytes, LINE_BYTES).
- R6: Only one chunk is outstanding. After the request handshake, `req_valid` stays low until a response, and the next chunk appears in the cycle after that response.
- R7: `req_store` is 1 for writes and 0 for reads. All request fields hold steady while `req_valid` is high and `req_ready` is low.
- R8: For writes, `wbuf_idx` gives the transfer byte index of the chunk being built, and byte k of `wbuf_data` is payload byte `wbuf_idx`+k. Lane `req_offset`+k of `req_wdata` carries payload byte k of the chunk, for k < `req_len`. All other lanes are zero.
- R9: For reads, one cycle after each response `rd_valid` pulses. Lane k of `rd_data` is lane (offset+k) of `rsp_data`, where offset is the start offset for the first chunk and 0 after it. `rd_be` has its low `req_len` bits set, lanes without an enable read zero, and `rd_idx` holds the chunk's transfer index. Writes never raise `rd_valid`.
- R10: One cycle after the final response, `done` pulses with `busy` already low, and a new request is accepted in that cycle.
- R11: A `rsp_valid` that arrives while a chunk is still waiting for `req_ready` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_valid | input | 1 | Transfer request present |
| xfer_addr | input | ADDR_W | Start byte address |
| xfer_len | input | LEN_W | Transfer length in bytes |
| xfer_write | input | 1 | 1 = write (store), 0 = read (load) |
| xfer_accept | output | 1 | Request taken this cycle |
| xfer_full | output | 1 | Request refused, transfer in progress |
| xfer_bad | output | 1 | Request refused, zero length |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wbuf_idx | output | LEN_W | Payload byte index wanted for the next write chunk |
| wbuf_data | input | 8*LINE_BYTES | Payload bytes from `wbuf_idx` upward, byte 0 in lane 0 |
| req_valid | output | 1 | Chunk request valid |
| req_ready | input | 1 | Memory side takes the chunk |
| req_line_addr | output | ADDR_W | Chunk line address, offset bits zero |
| req_offset | output | log2(LINE_BYTES) | Byte offset of the chunk in its line |
| req_len | output | log2(LINE_BYTES)+1 | Chunk length in bytes |
| req_store | output | 1 | 1 = store, 0 = load |
| req_wdata | output | 8*LINE_BYTES | Store data in line lanes |
| rsp_valid | input | 1 | Response or acknowledgement for the outstanding chunk |
| rsp_data | input | 8*LINE_BYTES | Load data for the whole line |
| rd_valid | output | 1 | Read chunk data valid |
| rd_data | output | 8*LINE_BYTES | Read chunk bytes, first byte in lane 0 |
| rd_be | output | LINE_BYTES | Byte enables for `rd_data` |
| rd_idx | output | LEN_W | Transfer byte index of `rd_data` lane 0 |

## Verification
The hardest cases to reach from the ports are the ones that arrive at awkward moments. A competing transfer request can land while a chunk is in flight, and a response can show up while the chunk has not yet been handed over. Neither happens with a well-behaved partner. The bench therefore injects a refused request during a response wait, and a response during a `req_ready` stall, inside transfers that are otherwise ordinary. It then checks that the following chunks keep their expected addresses and lengths. Transfers that end at exactly the completion cycle are chained back to back, so the same-cycle restart is exercised on every random transfer.

// File: rtl/dma_line_splitter.sv
module dma_line_splitter #(
  parameter int LINE_BYTES = 64,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      xfer_valid,
  input  logic [ADDR_W-1:0]         xfer_addr,
  input  logic [LEN_W-1:0]          xfer_len,
  input  logic                      xfer_write,
  output logic                      xfer_accept,
  output logic                      xfer_full,
  output logic                      xfer_bad,
  output logic                      busy,
  output logic                      done,
  output logic [LEN_W-1:0]          wbuf_idx,
  input  logic [8*LINE_BYTES-1:0]   wbuf_data,
  output logic                      req_valid,
  input  logic                      req_ready,
  output logic [ADDR_W-1:0]         req_line_addr,
  output logic [$clog2(LINE_BYTES)-1:0] req_offset,
  output logic [$clog2(LINE_BYTES):0]   req_len,
  output logic                      req_store,
  output logic [8*LINE_BYTES-1:0]   req_wdata,
  input  logic                      rsp_valid,
  input  logic [8*LINE_BYTES-1:0]   rsp_data,
  output logic                      rd_valid,
  output logic [8*LINE_BYTES-1:0]   rd_data,
  output logic [LINE_BYTES-1:0]     rd_be,
  output logic [LEN_W-1:0]          rd_idx
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int DATA_W = 8 * LINE_BYTES;
  localparam int CL_W   = OFS_W + 1;
  localparam logic [LEN_W-1:0] LINE_L = LEN_W'(LINE_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} state_t;
  state_t st;

  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  total_len, issued, completed;
  logic              is_wr;

  function automatic logic [LINE_BYTES-1:0] lane_mask(input logic [LEN_W-1:0] n);
    for (int i = 0; i < LINE_BYTES; i++) lane_mask[i] = (i < int'(n));
  endfunction

  function automatic logic [DATA_W-1:0] expand(input logic [LINE_BYTES-1:0] m);
    for (int i = 0; i < LINE_BYTES; i++) expand[i*8 +: 8] = {8{m[i]}};
  endfunction

  wire [OFS_W-1:0]  in_off     = xfer_addr[OFS_W-1:0];
  wire [LEN_W-1:0]  first_room = LINE_L - LEN_W'(in_off);
  wire [LEN_W-1:0]  first_len  = (xfer_len <= first_room) ? xfer_len : first_room;
  wire [LEN_W-1:0]  remaining  = total_len - issued;
  wire [LEN_W-1:0]  next_len   = (remaining < LINE_L) ? remaining : LINE_L;
  wire [ADDR_W-1:0] next_addr  = start_addr + ADDR_W'(issued);
  wire [LEN_W-1:0]  rsp_cnt    = issued - completed;
  wire [OFS_W-1:0]  rsp_off    = (completed == '0) ? start_addr[OFS_W-1:0] : '0;

  assign busy        = (st != S_IDLE);
  assign req_valid   = (st == S_SEND);
  assign xfer_accept = xfer_valid && !busy && (xfer_len != '0);
  assign xfer_full   = xfer_valid && busy;
  assign xfer_bad    = xfer_valid && !busy && (xfer_len == '0);
  assign wbuf_idx    = busy ? issued : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      start_addr    <= '0;
      total_len     <= '0;
      issued        <= '0;
      completed     <= '0;
      is_wr         <= 1'b0;
      req_line_addr <= '0;
      req_offset    <= '0;
      req_len       <= '0;
      req_store     <= 1'b0;
      req_wdata     <= '0;
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      rd_be         <= '0;
      rd_idx        <= '0;
      done          <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (xfer_accept) begin
          st            <= S_SEND;
          start_addr    <= xfer_addr;
          total_len     <= xfer_len;
          is_wr         <= xfer_write;
          issued        <= first_len;
          completed     <= '0;
          req_line_addr <= {xfer_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
          req_offset    <= in_off;
          req_len       <= CL_W'(first_len);
          req_store     <= xfer_write;
          req_wdata     <= xfer_write ?
                           (wbuf_data & expand(lane_mask(first_len))) << {in_off, 3'b000} : '0;
        end
        S_SEND: if (req_ready) st <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          completed <= issued;
          if (!is_wr) begin
            rd_valid <= 1'b1;
            rd_data  <= (rsp_data >> {rsp_off, 3'b000}) & expand(lane_mask(rsp_cnt));
            rd_be    <= lane_mask(rsp_cnt);
            rd_idx   <= completed;
          end
          if (issued == total_len) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            st            <= S_SEND;
            req_line_addr <= {next_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
            req_offset    <= next_addr[OFS_W-1:0];
            req_len       <= CL_W'(next_len);
            issued        <= issued + next_len;
            req_wdata     <= is_wr ? (wbuf_data & expand(lane_mask(next_len))) : '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_CHUNK_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) &&
      ((CL_W+1)'(req_offset) + (CL_W+1)'(req_len) <= (CL_W+1)'(LINE_BYTES))); // R4
  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (completed != '0) |-> req_offset == '0); // R5
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !req_valid && !rsp_valid |=> !req_valid); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_line_addr) &&
      $stable(req_offset) && $stable(req_len) && $stable(req_wdata)); // R7
  AST_XFER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(start_addr) && $stable(total_len)); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> issued <= total_len); // R5
endmodule

// File: tb/sim_dma_line_splitter.sv
module sim_dma_line_splitter;
  localparam int CLK_PERIOD = 10;
  localparam int LB = 64;
  localparam int AW = 32;
  localparam int LW = 16;
  localparam int DW = 8 * LB;

  logic clk = 0, rst_n = 0;
  logic xfer_valid = 0, xfer_write = 0;
  logic [AW-1:0] xfer_addr = '0;
  logic [LW-1:0] xfer_len = '0;
  logic xfer_accept, xfer_full, xfer_bad, busy, done;
  logic [LW-1:0] wbuf_idx;
  logic [DW-1:0] wbuf_data;
  logic req_valid, req_ready = 0, req_store;
  logic [AW-1:0] req_line_addr;
  logic [5:0] req_offset;
  logic [6:0] req_len;
  logic [DW-1:0] req_wdata;
  logic rsp_valid = 0;
  logic [DW-1:0] rsp_data = '0;
  logic rd_valid;
  logic [DW-1:0] rd_data;
  logic [LB-1:0] rd_be;
  logic [LW-1:0] rd_idx;

  int checks = 0, errors = 0, cyc = 0, tag = 0;

  dma_line_splitter #(.LINE_BYTES(LB), .ADDR_W(AW), .LEN_W(LW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pay_b(int t, int i);
    return 8'(i * 37 + t * 11 + 5);
  endfunction
  function automatic logic [7:0] mem_b(logic [31:0] a);
    return 8'((a * 29) ^ (a >> 7));
  endfunction

  always_comb
    for (int k = 0; k < LB; k++) wbuf_data[k*8 +: 8] = pay_b(tag, int'(wbuf_idx) + k);

  task automatic check(input bit ok, input string r, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %s expected %s", r, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic run_xfer(input logic [31:0] a, input int len, input bit w,
                          input bit try_full, input bit try_stray);
    int c = 0, off, n, d;
    bit first = 1;
    logic [DW-1:0] e;
    logic [AW-1:0] line;
    tag++;
    xfer_valid = 1; xfer_addr = a; xfer_len = LW'(len); xfer_write = w;
    #1;
    check(xfer_accept && !xfer_full && !xfer_bad, "R1/R10 accept", $sformatf("%b", xfer_accept), "1");
    @(posedge clk); @(negedge clk);
    xfer_valid = 0;
    check(busy, "R1 busy", $sformatf("%b", busy), "1");
    while (c < len) begin
      off = first ? int'(a % LB) : 0;
      n = (len - c < LB - off) ? len - c : LB - off;
      line = (a + AW'(c)) & ~AW'(LB - 1);
      check(req_valid, first ? "R4 req timing" : "R6 next req timing", $sformatf("%b", req_valid), "1");
      check(int'(req_offset) == off && int'(req_len) == n && req_line_addr == line,
            first ? "R4 chunk" : "R5 chunk",
            $sformatf("%h/%0d/%0d", req_line_addr, req_offset, req_len),
            $sformatf("%h/%0d/%0d", line, off, n));
      check(req_store == w, "R7 type", $sformatf("%b", req_store), $sformatf("%b", w));
      e = '0;
      if (w) for (int k = 0; k < n; k++) e[(off+k)*8 +: 8] = pay_b(tag, c + k);
      check(req_wdata == e, "R8 wdata", $sformatf("%h", req_wdata), $sformatf("%h", e));
      d = try_stray ? 2 : int'($urandom % 4);
      for (int i = 0; i < d; i++) begin
        if (try_stray && i == 0) rsp_valid = 1;
        @(posedge clk); @(negedge clk);
        if (rsp_valid) begin
          rsp_valid = 0;
          check(req_valid && !rd_valid && !done, "R11 stray rsp",
                $sformatf("%b%b%b", req_valid, rd_valid, done), "100");
        end
        check(req_valid && int'(req_len) == n && req_line_addr == line, "R7 hold",
              $sformatf("%b/%0d", req_valid, req_len), $sformatf("1/%0d", n));
      end
      req_ready = 1;
      @(posedge clk); @(negedge clk);
      req_ready = 0;
      d = int'($urandom % 4) + (try_full ? 1 : 0);
      for (int i = 0; i < d; i++) begin
        if (try_full && i == 0) begin
          xfer_valid = 1; xfer_addr = 32'h40; xfer_len = 5; xfer_write = ~w;
          #1;
          check(xfer_full && !xfer_accept, "R2 refuse", $sformatf("%b%b", xfer_full, xfer_accept), "10");
        end
        check(!req_valid, "R6 one in flight", $sformatf("%b", req_valid), "0");
        @(posedge clk); @(negedge clk);
        xfer_valid = 0;
      end
      check(!req_valid, "R6 wait", $sformatf("%b", req_valid), "0");
      for (int j = 0; j < LB; j++) rsp_data[j*8 +: 8] = w ? 8'($urandom) : mem_b(line + AW'(j));
      rsp_valid = 1;
      @(posedge clk); @(negedge clk);
      rsp_valid = 0;
      if (!w) begin
        e = '0;
        for (int k = 0; k < n; k++) e[k*8 +: 8] = mem_b(a + AW'(c + k));
        check(rd_valid && rd_data == e, "R9 rd_data", $sformatf("%b %h", rd_valid, rd_data), $sformatf("1 %h", e));
        check(rd_be == (LB'(1) << n) - LB'(1) || (n == LB && rd_be == '1), "R9 rd_be",
              $sformatf("%h", rd_be), $sformatf("%0d ones", n));
        check(int'(rd_idx) == c, "R9 rd_idx", $sformatf("%0d", rd_idx), $sformatf("%0d", c));
      end else
        check(!rd_valid, "R9 no rd on write", $sformatf("%b", rd_valid), "0");
      c += n;
      first = 0;
      if (c == len) check(done && !busy, "R10 done", $sformatf("%b%b", done, busy), "10");
      else check(!done && busy, "R10 not done", $sformatf("%b%b", done, busy), "01");
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !req_valid && !done && !rd_valid, "R1 reset",
          $sformatf("%b%b%b%b", busy, req_valid, done, rd_valid), "0000");
    rst_n = 1;
    @(negedge clk);
    xfer_valid = 1; xfer_addr = 32'h123; xfer_len = 0; xfer_write = 0;
    #1;
    check(xfer_bad && !xfer_accept, "R3 zero len", $sformatf("%b%b", xfer_bad, xfer_accept), "10");
    @(posedge clk); @(negedge clk);
    xfer_valid = 0;
    check(!busy && !req_valid, "R3 no start", $sformatf("%b%b", busy, req_valid), "00");
    run_xfer(32'h0000_103F, 1, 0, 0, 0);
    run_xfer(32'h0000_2000, 64, 1, 0, 0);
    run_xfer(32'h0000_303C, 8, 0, 1, 0);
    run_xfer(32'h0000_4001, 64, 1, 0, 1);
    run_xfer(32'h0000_5000, 200, 0, 0, 1);
    run_xfer(32'h0000_6017, 150, 1, 1, 0);
    for (int t = 0; t < 40; t++)
      run_xfer($urandom & 32'h00FF_FFFF, 1 + int'($urandom % 300), 1'($urandom),
               ($urandom % 5) == 0, ($urandom % 5) == 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule